// File: doc/BRIEF.md
# Conditional Upper-Word Logical Shifter

This execution unit serves a 16-bit DSP datapath. It takes one shift instruction, together with the operand values read from the register file, and produces a 40-bit destination value. The upper 16 bits of the 32-bit source word are shifted logically by a signed count. A non-negative count moves the bits toward the most significant end. A negative count moves them toward the least significant end. Vacated positions fill with zeros. The shifted halfword becomes bits 31:16 of the destination. The low halfword and the eight guard bits above bit 31 are always written as zero.

Four instruction encodings are accepted. Three of them are register forms: one always executes, one executes only when the incoming DC status bit is 1, and one executes only when it is 0. The fourth is an immediate form that takes a 7-bit count from the instruction and shifts the destination's own upper word. Only the two forms without a condition produce new status flags. A conditional form whose condition fails behaves as a no-op: it writes nothing and changes no flags.

Instructions arrive on a valid/ready input. Each accepted instruction yields exactly one result beat on a valid/ready output one cycle later. Back-pressure works as follows. While the output holds a beat that has not been taken, the input is not ready and the held beat does not change. When the output beat is taken in a cycle, a new instruction may be accepted in that same cycle.

Top module: `ushl_unit`

## Requirements
- R1: An instruction is recognised only when bits 31:26 equal 111110. Bits 15:8 of 0x81, 0x82 or 0x83 select the register forms, and bits 15:11 of 00000 select the immediate form. Every other word gives a beat with write enable 0 and flag enable 0.
- R2: In the register forms the source is bits 31:16 of the Sx operand and the count is bits 6:0 of the Sy operand, read as two's complement. In the immediate form the source is bits 31:16 of the incoming destination value and the count is instruction bits 10:4. A count of zero or more shifts left, a negative count shifts right by its magnitude, and both directions fill with zeros.
- R3: Count magnitudes of 16 or more act as 16, so the upper result word is all zeros.
- R4: Whenever a result is written, result bits 15:0 and the guard bits 39:32 are zero.
- R5: Form 0x82 writes only when DC in is 1, and form 0x83 writes only when DC in is 0. When the condition fails, the beat has write enable 0 and flag enable 0.
- R6: Flag enable is 1 exactly for form 0x81 and the immediate form. It is never 1 for a conditional form, even when that form executes.
- R7: The DC flag is the last bit shifted out of the source halfword: bit 16 minus the count on a left shift, and bit (magnitude - 1) on a right shift. It is 0 for a count of zero.
- R8: The N flag equals result bit 31. Z is 1 when the 40-bit result is zero. V is always 0. GT is 1 when N and Z are both 0.
- R9: The input is ready exactly when the output is empty or being taken. An accepted instruction appears on the output in the next cycle. A beat that is not taken stays valid and unchanged, and every accepted instruction gives exactly one beat.
- R10: The destination index output carries instruction bits 3:0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction and operands valid |
| in_ready | output | 1 | Unit can accept an instruction |
| in_instr | input | 32 | Instruction word |
| in_sx | input | 32 | Source operand (upper half used) |
| in_sy | input | 32 | Count operand (bits 6:0 used) |
| in_dz | input | 40 | Current destination value (immediate-form source) |
| in_dc | input | 1 | Current DC status bit used by the conditional forms |
| out_valid | output | 1 | Result beat valid |
| out_ready | input | 1 | Consumer takes the result beat |
| out_wr_en | output | 1 | Destination register should be written |
| out_dst | output | 4 | Destination register index |
| out_result | output | 40 | Value to write to the destination |
| out_flag_we | output | 1 | Status flags should be updated |
| out_dc | output | 1 | New DC flag |
| out_n | output | 1 | New N flag |
| out_z | output | 1 | New Z flag |
| out_v | output | 1 | New V flag |
| out_gt | output | 1 | New GT flag |

## Verification
Two things can happen in the same cycle: a held result beat is drained, and a fresh instruction is accepted behind it. The bench drives out_ready at random while instructions keep arriving, so an accept often lands on the edge where the previous beat leaves. A behavioural queue model then confirms that no beat is lost, repeated or changed. A second overlap matters as well: a conditional form whose condition holds still writes its result while its flags stay suppressed. Directed stimulus covers both DC values for every form, and each beat's write enable and flag enable are judged separately.

// File: rtl/ushl_pkg.sv
package ushl_pkg;
  localparam int INSTR_W   = 32;
  localparam int PREFIX_W  = 6;
  localparam int SUB_W     = 8;
  localparam int IMM_TAG_W = 5;
  localparam int CNT_W     = 7;
  localparam int IDX_W     = 4;

  localparam logic [PREFIX_W-1:0]  OPC_PREFIX  = 6'b111110;
  localparam logic [SUB_W-1:0]     SUB_ALWAYS  = 8'h81;
  localparam logic [SUB_W-1:0]     SUB_IF_SET  = 8'h82;
  localparam logic [SUB_W-1:0]     SUB_IF_CLR  = 8'h83;
  localparam logic [IMM_TAG_W-1:0] SUB_IMM_TAG = 5'b00000;

  typedef enum logic [2:0] {
    OP_NONE,
    OP_REG_ALWAYS,
    OP_REG_IF_SET,
    OP_REG_IF_CLR,
    OP_IMM
  } ushl_op_e;

  typedef struct packed {
    logic dc;
    logic n;
    logic z;
    logic v;
    logic gt;
  } ushl_flags_t;
endpackage

// File: rtl/ushl_decode.sv
module ushl_decode
  import ushl_pkg::*;
(
  input  logic [INSTR_W-1:0] instr,
  input  logic               cond_bit,
  output ushl_op_e           op,
  output logic               exec,
  output logic               flag_upd,
  output logic               use_imm,
  output logic [CNT_W-1:0]   imm_cnt,
  output logic [IDX_W-1:0]   dst_idx
);
  localparam int HI_LSB  = INSTR_W - PREFIX_W;
  localparam int SUB_LSB = INSTR_W/2 - SUB_W;
  localparam int TAG_LSB = INSTR_W/2 - IMM_TAG_W;

  logic [PREFIX_W-1:0]  prefix;
  logic [SUB_W-1:0]     sub;
  logic [IMM_TAG_W-1:0] tag;

  assign prefix  = instr[INSTR_W-1:HI_LSB];
  assign sub     = instr[INSTR_W/2-1:SUB_LSB];
  assign tag     = instr[INSTR_W/2-1:TAG_LSB];
  assign imm_cnt = instr[IDX_W+CNT_W-1:IDX_W];
  assign dst_idx = instr[IDX_W-1:0];

  always_comb begin
    op = OP_NONE;
    if (prefix == OPC_PREFIX) begin
      if (sub == SUB_ALWAYS)       op = OP_REG_ALWAYS;
      else if (sub == SUB_IF_SET)  op = OP_REG_IF_SET;
      else if (sub == SUB_IF_CLR)  op = OP_REG_IF_CLR;
      else if (tag == SUB_IMM_TAG) op = OP_IMM;
    end
  end

  always_comb begin
    unique case (op)
      OP_REG_ALWAYS, OP_IMM: exec = 1'b1;
      OP_REG_IF_SET:         exec = cond_bit;
      OP_REG_IF_CLR:         exec = ~cond_bit;
      default:               exec = 1'b0;
    endcase
  end

  assign flag_upd = (op == OP_REG_ALWAYS) || (op == OP_IMM);
  assign use_imm  = (op == OP_IMM);
endmodule

// File: rtl/ushl_count.sv
module ushl_count #(
  parameter int WORD_W = 16,
  parameter int CNT_W  = 7,
  localparam int MAG_W = $clog2(WORD_W) + 1
) (
  input  logic [CNT_W-1:0] cnt,
  output logic             left,
  output logic [MAG_W-1:0] mag
);
  logic [CNT_W:0] absv;

  always_comb begin
    left = ~cnt[CNT_W-1];
    absv = left ? {1'b0, cnt} : ({1'b0, ~cnt} + 1'b1);
    if (absv > (CNT_W+1)'(WORD_W)) mag = MAG_W'(WORD_W);
    else                           mag = absv[MAG_W-1:0];
  end
endmodule

// File: rtl/ushl_shifter.sv
module ushl_shifter #(
  parameter int WORD_W = 16,
  localparam int MAG_W = $clog2(WORD_W) + 1,
  localparam int IW    = $clog2(WORD_W)
) (
  input  logic [WORD_W-1:0] src,
  input  logic              left,
  input  logic [MAG_W-1:0]  mag,
  output logic [WORD_W-1:0] res,
  output logic              last_out
);
  logic [WORD_W-1:0] stg [0:MAG_W];
  logic [MAG_W-1:0]  idx;

  assign stg[0] = src;

  generate
    for (genvar k = 0; k < MAG_W; k++) begin : g_stage
      assign stg[k+1] = mag[k] ? (left ? (stg[k] << (2**k)) : (stg[k] >> (2**k)))
                               : stg[k];
    end
  endgenerate

  assign res = stg[MAG_W];

  always_comb begin
    idx = left ? (MAG_W'(WORD_W) - mag) : (mag - 1'b1);
    if (mag == '0) last_out = 1'b0;
    else           last_out = src[idx[IW-1:0]];
  end
endmodule

// File: rtl/ushl_flags.sv
module ushl_flags
  import ushl_pkg::*;
#(
  parameter int WORD_W = 16
) (
  input  logic [WORD_W-1:0] res,
  input  logic              last_out,
  output ushl_flags_t       flg
);
  always_comb begin
    flg.dc = last_out;
    flg.n  = res[WORD_W-1];
    flg.z  = ~|res;
    flg.v  = 1'b0;
    flg.gt = ~flg.n & ~flg.z;
  end
endmodule

// File: rtl/ushl_unit.sv
module ushl_unit
  import ushl_pkg::*;
#(
  parameter int WORD_W  = 16,
  parameter int GUARD_W = 8,
  localparam int OPND_W = 2*WORD_W,
  localparam int REG_W  = OPND_W + GUARD_W,
  localparam int MAG_W  = $clog2(WORD_W) + 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [INSTR_W-1:0]  in_instr,
  input  logic [OPND_W-1:0]   in_sx,
  input  logic [OPND_W-1:0]   in_sy,
  input  logic [REG_W-1:0]    in_dz,
  input  logic                in_dc,
  output logic                out_valid,
  input  logic                out_ready,
  output logic                out_wr_en,
  output logic [IDX_W-1:0]    out_dst,
  output logic [REG_W-1:0]    out_result,
  output logic                out_flag_we,
  output logic                out_dc,
  output logic                out_n,
  output logic                out_z,
  output logic                out_v,
  output logic                out_gt
);
  ushl_op_e           op;
  logic               exec, flag_upd, use_imm, left, last_out, fire;
  logic [CNT_W-1:0]   imm_cnt, cnt_sel;
  logic [IDX_W-1:0]   dst_idx;
  logic [MAG_W-1:0]   mag;
  logic [WORD_W-1:0]  src, res;
  logic [REG_W-1:0]   full;
  ushl_flags_t        flg;

  ushl_decode u_dec (
    .instr(in_instr), .cond_bit(in_dc), .op(op), .exec(exec),
    .flag_upd(flag_upd), .use_imm(use_imm), .imm_cnt(imm_cnt), .dst_idx(dst_idx)
  );

  assign cnt_sel = use_imm ? imm_cnt : in_sy[CNT_W-1:0];
  assign src     = use_imm ? in_dz[OPND_W-1:WORD_W] : in_sx[OPND_W-1:WORD_W];

  ushl_count #(.WORD_W(WORD_W), .CNT_W(CNT_W)) u_cnt (
    .cnt(cnt_sel), .left(left), .mag(mag)
  );

  ushl_shifter #(.WORD_W(WORD_W)) u_shf (
    .src(src), .left(left), .mag(mag), .res(res), .last_out(last_out)
  );

  ushl_flags #(.WORD_W(WORD_W)) u_flg (
    .res(res), .last_out(last_out), .flg(flg)
  );

  assign full     = {{GUARD_W{1'b0}}, res, {WORD_W{1'b0}}};
  assign in_ready = ~out_valid | out_ready;
  assign fire     = in_valid & in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      out_wr_en   <= 1'b0;
      out_flag_we <= 1'b0;
      out_dst     <= '0;
      out_result  <= '0;
      out_dc      <= 1'b0;
      out_n       <= 1'b0;
      out_z       <= 1'b0;
      out_v       <= 1'b0;
      out_gt      <= 1'b0;
    end else if (fire) begin
      out_valid   <= 1'b1;
      out_wr_en   <= exec;
      out_flag_we <= exec & flag_upd;
      out_dst     <= dst_idx;
      out_result  <= exec ? full : '0;
      out_dc      <= flg.dc;
      out_n       <= flg.n;
      out_z       <= flg.z;
      out_v       <= flg.v;
      out_gt      <= flg.gt;
    end else if (out_ready) begin
      out_valid   <= 1'b0;
    end
  end
endmodule

// File: rtl/ushl_unit_chk.sv
module ushl_unit_chk #(
  parameter int WORD_W  = 16,
  parameter int GUARD_W = 8,
  localparam int REG_W  = 2*WORD_W + GUARD_W
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic             out_valid,
  input logic             out_ready,
  input logic             out_wr_en,
  input logic [REG_W-1:0] out_result,
  input logic             out_flag_we,
  input logic             out_n,
  input logic             out_z,
  input logic             out_v,
  input logic             out_gt
);
  // R4: low halfword cleared on every write
  p_low_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_wr_en |-> out_result[WORD_W-1:0] == '0);

  // R4: guard bits cleared on every write
  p_guard_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_wr_en |-> out_result[REG_W-1:2*WORD_W] == '0);

  // R5 / R6: a beat that writes nothing updates no flags
  p_noop_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_wr_en |-> !out_flag_we);

  // R8: V never set
  p_v_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_flag_we |-> !out_v);

  // R8: exactly one of N, Z, GT
  p_sign_class_r8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_flag_we |-> $countones({out_n, out_z, out_gt}) == 1);

  // R9: an accepted instruction appears next cycle
  p_accept_next_r9: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid);

  // R9: a stalled beat is held unchanged
  p_stall_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_result) && $stable(out_wr_en)
                                && $stable(out_flag_we));
endmodule

bind ushl_unit ushl_unit_chk #(.WORD_W(WORD_W), .GUARD_W(GUARD_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready), .out_wr_en(out_wr_en),
  .out_result(out_result), .out_flag_we(out_flag_we), .out_n(out_n),
  .out_z(out_z), .out_v(out_v), .out_gt(out_gt)
);

// File: tb/sim_ushl_unit.sv
module sim_ushl_unit;
  localparam int TXN      = 3000;
  localparam int N_DIRECT = 96;
  localparam int WDOG     = 150000;

  typedef struct packed {
    logic [2:0]  kind;
    logic        big;
    logic        wr;
    logic        fwe;
    logic [3:0]  dst;
    logic [39:0] res;
    logic        dc, n, z, v, gt;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0, in_ready, in_dc = 1'b0;
  logic [31:0] in_instr = '0, in_sx = '0, in_sy = '0;
  logic [39:0] in_dz = '0;
  logic        out_valid, out_ready = 1'b0, out_wr_en, out_flag_we;
  logic [3:0]  out_dst;
  logic [39:0] out_result;
  logic        out_dc, out_n, out_z, out_v, out_gt;

  int n_cmp = 0, n_bad = 0, issued = 0;
  bit done = 0;
  exp_t q[$];
  int dcnt[11] = '{0, 1, 15, 16, 17, -1, -15, -16, -17, -64, 63};

  always #10 clk = ~clk;

  ushl_unit u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_instr(in_instr), .in_sx(in_sx), .in_sy(in_sy), .in_dz(in_dz), .in_dc(in_dc),
    .out_valid(out_valid), .out_ready(out_ready), .out_wr_en(out_wr_en),
    .out_dst(out_dst), .out_result(out_result), .out_flag_we(out_flag_we),
    .out_dc(out_dc), .out_n(out_n), .out_z(out_z), .out_v(out_v), .out_gt(out_gt)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [39:0] act, input logic [39:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic report();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  function automatic exp_t model(logic [31:0] ins, logic [31:0] sx, logic [31:0] sy,
                                 logic [39:0] dz, logic dcin);
    exp_t e;
    logic [6:0]  raw;
    logic [15:0] src, r;
    int c, m;
    e = '0;
    e.dst = ins[3:0];
    if (ins[31:26] != 6'b111110)  e.kind = 3'd0;
    else if (ins[15:8] == 8'h81)  e.kind = 3'd1;
    else if (ins[15:8] == 8'h82)  e.kind = 3'd2;
    else if (ins[15:8] == 8'h83)  e.kind = 3'd3;
    else if (ins[15:11] == 5'b0)  e.kind = 3'd4;
    else                          e.kind = 3'd0;
    raw = (e.kind == 3'd4) ? ins[10:4] : sy[6:0];
    src = (e.kind == 3'd4) ? dz[31:16] : sx[31:16];
    c = int'($signed(raw));
    m = (c < 0) ? -c : c;
    if (m > 16) m = 16;
    e.big = (m >= 16);
    if (c >= 0) begin
      r = 16'((32'(src) << m));
      e.dc = (m == 0) ? 1'b0 : src[16-m];
    end else begin
      r = src >> m;
      e.dc = src[m-1];
    end
    e.wr  = (e.kind == 3'd1) || (e.kind == 3'd4) || (e.kind == 3'd2 && dcin)
            || (e.kind == 3'd3 && !dcin);
    e.fwe = (e.kind == 3'd1) || (e.kind == 3'd4);
    e.res = {8'h00, r, 16'h0000};
    e.n   = r[15];
    e.z   = (r == 16'h0);
    e.v   = 1'b0;
    e.gt  = !e.n && !e.z;
    return e;
  endfunction

  task automatic make_stim(input int idx);
    int kind, c, variant;
    logic [15:0] hi, lo;
    logic [3:0]  xy, z;
    xy = 4'($urandom);
    z  = 4'($urandom);
    hi = {6'b111110, 10'($urandom)};
    in_sx = $urandom;
    in_sy = $urandom;
    in_dz = {8'($urandom), 32'($urandom)};
    in_dc = 1'($urandom);
    variant = 0;
    if (idx < 88) begin
      kind  = 1 + idx / 22;
      c     = dcnt[(idx % 22) / 2];
      in_dc = 1'(idx % 2);
    end else if (idx < N_DIRECT) begin
      kind = 0;
      c = 3;
      variant = (idx - 88) % 4;
    end else begin
      kind = $urandom_range(0, 5);
      if (kind == 5) kind = 1;
      c = $urandom_range(0, 127) - 64;
      variant = $urandom_range(0, 3);
    end
    in_sy[6:0] = 7'(c);
    case (kind)
      1: lo = {8'h81, xy, z};
      2: lo = {8'h82, xy, z};
      3: lo = {8'h83, xy, z};
      4: lo = {5'b00000, 7'(c), z};
      default: begin
        case (variant)
          0: begin hi = {6'b111111, 10'($urandom)}; lo = {8'h81, xy, z}; end
          1: lo = {8'h80, xy, z};
          2: lo = {8'h84, xy, z};
          default: lo = {5'b00001, 7'(c), z};
        endcase
      end
    endcase
    in_instr = {hi, lo};
  endtask

  initial begin : watchdog
    #(WDOG * 20);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL R9 watchdog: actual=%0d expected=%0d", issued, TXN);
      report();
    end
  end

  initial begin : driver
    bit hold;
    exp_t e;
    hold = 0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk(out_valid == 1'b0, "R9", "out_valid after reset", 40'(out_valid), 40'h0);
    rst_n = 1'b1;
    while (issued < TXN || q.size() != 0) begin
      @(negedge clk);
      if (!hold) begin
        if (issued < TXN && $urandom_range(0, 9) < 8) begin
          make_stim(issued);
          in_valid = 1'b1;
        end else begin
          in_valid = 1'b0;
        end
      end
      out_ready = (issued >= TXN) ? 1'b1 : ($urandom_range(0, 9) < 7);
      #1;
      chk(in_ready == (!out_valid || out_ready), "R9", "in_ready",
          40'(in_ready), 40'(!out_valid || out_ready));
      if (out_valid && out_ready) begin
        if (q.size() == 0) begin
          chk(1'b0, "R9", "unexpected beat", 40'(out_dst), 40'h0);
        end else begin
          e = q.pop_front();
          chk(out_wr_en == e.wr, (e.kind == 3'd2 || e.kind == 3'd3) ? "R5" : "R1",
              "write enable", 40'(out_wr_en), 40'(e.wr));
          chk(out_flag_we == e.fwe, (e.kind == 3'd2 || e.kind == 3'd3) ? "R6" : "R1",
              "flag enable", 40'(out_flag_we), 40'(e.fwe));
          chk(out_dst == e.dst, "R10", "destination index", 40'(out_dst), 40'(e.dst));
          if (e.wr) begin
            chk(out_result[31:16] == e.res[31:16], e.big ? "R3" : "R2", "upper word",
                40'(out_result[31:16]), 40'(e.res[31:16]));
            chk(out_result[39:32] == 8'h0 && out_result[15:0] == 16'h0, "R4",
                "cleared bits", out_result, e.res);
          end
          if (e.fwe) begin
            chk(out_dc == e.dc, "R7", "DC flag", 40'(out_dc), 40'(e.dc));
            chk({out_n, out_z, out_v, out_gt} == {e.n, e.z, e.v, e.gt}, "R8",
                "N Z V GT", 40'({out_n, out_z, out_v, out_gt}), 40'({e.n, e.z, e.v, e.gt}));
          end
        end
      end
      if (in_valid && in_ready) begin
        q.push_back(model(in_instr, in_sx, in_sy, in_dz, in_dc));
        issued++;
        hold = 0;
      end else begin
        hold = in_valid;
      end
    end
    @(negedge clk);
    chk(out_valid == 1'b0, "R9", "drained", 40'(out_valid), 40'h0);
    done = 1;
    report();
  end
endmodule